// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt

This unit watches a running BCD calendar (seconds, minutes, hours, weekday, day of month, month, year) that another block maintains and supplies as inputs. It holds seven alarm fields in a staged copy and an active copy. Software writes the staged copy one field at a time, then issues a load command that moves all seven fields into the active copy at once. Each field carries its own match-enable flag, so any field can be left out of the comparison. The usual case is an alarm that ignores the weekday.

On each one-second tick the unit compares every enabled active field against the calendar. When all enabled fields agree, it sets a sticky pending flag. The interrupt line is the pending flag gated by an interrupt-enable bit. Software clears the pending flag by writing a one to it. A single write port covers staging, load, interrupt enable and status clear.

Register addresses on `wr_addr`:

| Address | Register |
|---|---|
| 0 | seconds |
| 1 | minutes |
| 2 | hours |
| 3 | weekday |
| 4 | day of month |
| 5 | month |
| 6 | year |
| 7 | load command |
| 8 | interrupt enable |
| 9 | status |

Top module: `alarm_unit`

## Requirements
- R1: Writing a field (addresses 0..6) changes only the staged copy. The compare uses the staged values only from the cycle after a write to address 7 with bit 15 set, which copies all seven staged fields into the active copy.
- R2: A write to address 7 with bit 15 clear leaves the active copy unchanged.
- R3: Bit 15 of each field write is that field's match enable. A field whose enable is 0 is ignored in the compare. For example, the weekday may mismatch while all other fields are enabled and equal.
- R4: The pending flag is set at the clock edge that samples `tick`=1 when every enabled active field equals the corresponding calendar input. Without `tick`, or with any enabled field unequal, it is not set.
- R5: When no active field is enabled, no match ever occurs.
- R6: Writing address 9 with bit 0 = 1 clears the pending flag at that edge. Writing it with bit 0 = 0 has no effect.
- R7: If a match and a clear of the pending flag fall at the same edge, the pending flag ends up set.
- R8: `alarm_irq` is registered and equals pending AND the interrupt-enable bit. The interrupt-enable bit is bit 0 of a write to address 8. Both change at the same edge as the flags.
- R9: After synchronous reset, the pending flag, `alarm_irq`, the interrupt enable and every staged and active field enable are 0.
- R10: A field write keeps only the field's own width: seconds 7, minutes 7, hours 6, weekday 3, day 6, month 5, year 8 bits, taken from `wr_data[7:0]`. Higher value bits are ignored in the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per calendar second |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_wday | input | 3 | Calendar weekday |
| cal_mday | input | 6 | Calendar day of month, BCD |
| cal_mon | input | 5 | Calendar month, BCD |
| cal_year | input | 8 | Calendar year offset, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| alarm_pending | output | 1 | Sticky alarm status flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
A matching tick and a write-one clear of the status can land on the same clock edge. A load command can also coincide with a tick, and in that case the compare still uses the previous active set. The bench provokes the first collision directly by driving a clear together with a matching tick. It then expects the flag to remain set.

Long random runs mix ticks, field writes, loads and clears freely, so both collisions recur many times. A bench model that evaluates the match against the old active copy before applying writes judges every cycle.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NUM_FIELDS  = 7;
  localparam int FIELD_MAX_W = 8;
  localparam int REG_W       = 16;
  localparam int ADDR_W      = 4;
  localparam int FLAG_BIT    = 15;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC  = 4'd0, A_MIN  = 4'd1, A_HOUR = 4'd2, A_WDAY = 4'd3,
    A_MDAY = 4'd4, A_MON  = 4'd5, A_YEAR = 4'd6, A_LOAD = 4'd7,
    A_IEN  = 4'd8, A_STAT = 4'd9
  } reg_addr_e;

  typedef struct packed {
    logic                   en;
    logic [FIELD_MAX_W-1:0] val;
  } alarm_field_t;

  function automatic int field_w(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 4:    return 6;
      3:       return 3;
      5:       return 5;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/alarm_stage_bank.sv
module alarm_stage_bank
  import alarm_cmp_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic                                  wr_flag,
  input  logic [FIELD_MAX_W-1:0]                wr_val,
  output alarm_field_t [NUM_FIELDS-1:0]         active_o
);
  alarm_field_t [NUM_FIELDS-1:0] staged_q;
  alarm_field_t [NUM_FIELDS-1:0] active_q;
  logic load_fire;

  assign load_fire = wr_en && (wr_addr == A_LOAD) && wr_flag;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int W = field_w(g);
    localparam logic [FIELD_MAX_W-1:0] MASK = FIELD_MAX_W'((1 << W) - 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        staged_q[g] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        staged_q[g].en  <= wr_flag;
        staged_q[g].val <= wr_val & MASK;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)            active_q[g] <= '0;
      else if (load_fire) active_q[g] <= staged_q[g];
    end
  end

  assign active_o = active_q;

  // R1
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_fire |=> $stable(active_q));
endmodule

// File: rtl/alarm_field_match.sv
module alarm_field_match #(
  parameter int W     = 7,
  parameter int MAX_W = 8
) (
  input  logic [MAX_W-1:0] cal,
  input  logic [MAX_W-1:0] alm,
  input  logic             en,
  output logic             hit,
  output logic             used
);
  localparam logic [MAX_W-1:0] MASK = MAX_W'((1 << W) - 1);

  assign used = en;
  assign hit  = !en || ((cal & MASK) == (alm & MASK));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic ien_wr,
  input  logic ien_val,
  output logic pending_o,
  output logic irq_o
);
  logic pend_q, en_q, irq_q;
  logic pend_d, en_d;

  always_comb begin
    pend_d = set_req | (pend_q & ~clr_req);
    en_d   = ien_wr ? ien_val : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= pend_d & en_d;
    end
  end

  assign pending_o = pend_q;
  assign irq_o     = irq_q;

  // R4
  pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(set_req));
  // R6
  pend_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(clr_req));
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_req |=> pend_q);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (pend_q && en_q));
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [6:0]        cal_sec,
  input  logic [6:0]        cal_min,
  input  logic [5:0]        cal_hour,
  input  logic [2:0]        cal_wday,
  input  logic [5:0]        cal_mday,
  input  logic [4:0]        cal_mon,
  input  logic [7:0]        cal_year,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic              alarm_pending,
  output logic              alarm_irq
);
  alarm_field_t [NUM_FIELDS-1:0] active;
  logic [FIELD_MAX_W-1:0] cal_vec [NUM_FIELDS];
  logic [NUM_FIELDS-1:0]  hit_v, used_v;
  logic set_req, clr_req, ien_wr;
  logic unused_hi;

  assign unused_hi = ^wr_data[FLAG_BIT-1:FIELD_MAX_W];

  always_comb begin
    cal_vec[0] = FIELD_MAX_W'(cal_sec);
    cal_vec[1] = FIELD_MAX_W'(cal_min);
    cal_vec[2] = FIELD_MAX_W'(cal_hour);
    cal_vec[3] = FIELD_MAX_W'(cal_wday);
    cal_vec[4] = FIELD_MAX_W'(cal_mday);
    cal_vec[5] = FIELD_MAX_W'(cal_mon);
    cal_vec[6] = cal_year;
  end

  alarm_stage_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_flag  (wr_data[FLAG_BIT]),
    .wr_val   (wr_data[FIELD_MAX_W-1:0]),
    .active_o (active)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    alarm_field_match #(.W(field_w(g)), .MAX_W(FIELD_MAX_W)) u_match (
      .cal  (cal_vec[g]),
      .alm  (active[g].val),
      .en   (active[g].en),
      .hit  (hit_v[g]),
      .used (used_v[g])
    );
  end

  assign set_req = tick && (&hit_v) && (|used_v);
  assign clr_req = wr_en && (wr_addr == A_STAT) && wr_data[0];
  assign ien_wr  = wr_en && (wr_addr == A_IEN);

  alarm_irq_ctrl u_irq (
    .clk       (clk),
    .rst       (rst),
    .set_req   (set_req),
    .clr_req   (clr_req),
    .ien_wr    (ien_wr),
    .ien_val   (wr_data[0]),
    .pending_o (alarm_pending),
    .irq_o     (alarm_irq)
  );

  // R5
  no_enable_no_match_chk: assert property (@(posedge clk) disable iff (rst)
    (used_v == '0) |-> !set_req);
endmodule

// File: tb/alarm_unit_tb.sv
module alarm_unit_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, tick, wr_en, alarm_pending, alarm_irq;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [7:0]  cal [7];

  alarm_unit u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .cal_sec(cal[0][6:0]), .cal_min(cal[1][6:0]), .cal_hour(cal[2][5:0]),
    .cal_wday(cal[3][2:0]), .cal_mday(cal[4][5:0]), .cal_mon(cal[5][4:0]),
    .cal_year(cal[6]), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alarm_pending(alarm_pending), .alarm_irq(alarm_irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] st_v [7], ac_v [7];
  logic       st_e [7], ac_e [7];
  logic       m_en, m_pend, m_irq;
  logic [7:0] golden [7] = '{8'h45, 8'h30, 8'h23, 8'h05, 8'h31, 8'h12, 8'h69};

  function automatic logic [7:0] fmask(int i);
    case (i)
      0, 1: return 8'h7F;
      2, 4: return 8'h3F;
      3:    return 8'h07;
      5:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic model_match();
    logic used = 0, all = 1;
    for (int i = 0; i < 7; i++)
      if (ac_e[i]) begin
        used = 1;
        if ((cal[i] & fmask(i)) != ac_v[i]) all = 0;
      end
    return used && all;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 7; i++) begin st_v[i]=0; ac_v[i]=0; st_e[i]=0; ac_e[i]=0; end
    m_en = 0; m_pend = 0; m_irq = 0;
  endtask

  task automatic cycle(string tag);
    logic set, clr;
    @(posedge clk);
    set = tick && model_match();
    clr = wr_en && wr_addr == 4'd9 && wr_data[0];
    if (wr_en) begin
      if (wr_addr < 7) begin
        st_v[wr_addr] = wr_data[7:0] & fmask(int'(wr_addr));
        st_e[wr_addr] = wr_data[15];
      end else if (wr_addr == 7 && wr_data[15]) begin
        for (int i = 0; i < 7; i++) begin ac_v[i] = st_v[i]; ac_e[i] = st_e[i]; end
      end else if (wr_addr == 8) m_en = wr_data[0];
    end
    m_pend = set | (m_pend & ~clr);
    m_irq  = m_pend & m_en;
    @(negedge clk);
    check({tag, " pending"}, alarm_pending, m_pend);
    check({tag, " irq"}, alarm_irq, m_irq);
  endtask

  task automatic op(logic we, logic [3:0] a, logic [15:0] d, logic tk, string tag);
    wr_en = we; wr_addr = a; wr_data = d; tick = tk;
    cycle(tag);
    wr_en = 0; wr_addr = 0; wr_data = 0; tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    for (int i = 0; i < 7; i++) cal[i] = golden[i];
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R9 reset pending", alarm_pending, 1'b0);
    check("R9 reset irq", alarm_irq, 1'b0);

    op(0, 0, 0, 1, "R5 no field enabled");
    check("R5 direct", alarm_pending, 1'b0);

    for (int i = 0; i < 7; i++)
      op(1, 4'(i), {(i != 3), 7'b0, golden[i]}, 0, "R1 stage");
    op(0, 0, 0, 1, "R1 staged not active");
    check("R1 direct", alarm_pending, 1'b0);
    op(1, 7, 16'h8000, 0, "R1 load");
    cal[3] = 8'h02;
    op(0, 0, 0, 1, "R3 weekday excluded");
    check("R3 direct", alarm_pending, 1'b1);
    check("R8 irq masked", alarm_irq, 1'b0);
    op(1, 8, 16'h0001, 0, "R8 enable");
    check("R8 direct", alarm_irq, 1'b1);
    op(1, 9, 16'h0000, 0, "R6 write zero");
    check("R6 zero no effect", alarm_pending, 1'b1);
    op(1, 9, 16'h0001, 0, "R6 write one");
    check("R6 cleared", alarm_pending, 1'b0);
    check("R8 irq follows", alarm_irq, 1'b0);
    op(0, 0, 0, 0, "R4 no tick");
    check("R4 no tick direct", alarm_pending, 1'b0);
    op(1, 9, 16'h0001, 1, "R7 clear with match");
    check("R7 direct", alarm_pending, 1'b1);
    op(1, 9, 16'h0001, 0, "R6 clear");
    cal[0] = 8'h46;
    op(0, 0, 0, 1, "R4 mismatch");
    check("R4 mismatch direct", alarm_pending, 1'b0);
    op(1, 0, 16'h8046, 0, "R2 stage");
    op(1, 7, 16'h7FFF, 0, "R2 no load");
    op(0, 0, 0, 1, "R2 old set kept");
    check("R2 direct", alarm_pending, 1'b0);
    cal[0] = 8'h45;
    op(0, 0, 0, 1, "R2 old value matches");
    check("R2 old match", alarm_pending, 1'b1);
    op(1, 9, 16'h0001, 0, "R6 clear");
    op(1, 0, 16'h80C5, 0, "R10 stage wide");
    op(1, 7, 16'h8000, 0, "R10 load");
    op(0, 0, 0, 1, "R10 masked match");
    check("R10 direct", alarm_pending, 1'b1);

    for (int n = 0; n < 4000; n++) begin
      int a;
      for (int i = 0; i < 7; i++) cal[i] = golden[i] + 8'($urandom % 2);
      a = $urandom % 14;
      if (a < 10) begin
        logic [15:0] d;
        d = {($urandom % 4 != 0), 7'b0, golden[a % 7] + 8'($urandom % 2)};
        if ($urandom % 8 == 0) d[7] = 1'b1;
        if (a >= 7) d = 16'($urandom);
        op(1, 4'(a), d, ($urandom % 2 == 1), "R4 R6 R7 R8 random");
      end else begin
        op(0, 0, 0, ($urandom % 2 == 1), "R4 random tick");
      end
    end
    finish_run();
  end
endmodule